// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 64-bit integer ALU that views each operand as a row of independent lanes: eight 8-bit lanes, four 16-bit lanes, or two 32-bit lanes. A size field selects the lane layout. The block performs lane-wise add and subtract, bitwise logic, lane-wise shifts, lane masks from compares, and narrowing packs. Add and subtract either wrap or clamp each lane to its limit. Every operation ends at lane boundaries, so one instruction processes several small integers side by side.

The arithmetic is combinational and feeds a single output register. A request presented with `in_valid` high on one clock edge shows its result, with `out_valid` high, after that edge. In idle cycles the result register keeps its value. Multiply and multiply-add are not provided.

Top module: `simd_alu`

## Requirements
- R1: `lane_size` selects the lane layout: 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, and 2 or 3 give two 32-bit lanes. Lane k occupies bits [k*W+W-1 : k*W]. No carry or borrow crosses a lane boundary in any operation.
- R2: Opcode 0 adds and opcode 1 subtracts (A minus B) lane by lane. With `sat_mode` 0 or 3, each lane wraps modulo 2^W.
- R3: With `sat_mode` 1 (signed), an add or subtract that overflows a lane clamps it to the most positive value (0 followed by ones) or the most negative value (1 followed by zeros) of that lane width.
- R4: With `sat_mode` 2 (unsigned), an add that overflows a lane gives all ones, and a subtract that underflows a lane gives zero.
- R5: Opcodes 2 (A AND B), 3 (A AND NOT B), 4 (A OR B) and 5 (A XOR B) act on all 64 bits, whatever `lane_size` is.
- R6: Opcodes 6 (logical left), 7 (logical right) and 8 (arithmetic right) shift every lane of A by the unsigned count held in B[7:0].
- R7: A shift count equal to or larger than the lane width gives zero for opcodes 6 and 7, and a lane filled with its sign bit for opcode 8.
- R8: Opcode 9 (equal) and opcode 10 (signed A greater than B) set each result lane to all ones when the condition is true and to all zeros when it is false.
- R9: Opcode 11 packs with signed saturation. With `lane_size` 1, each 16-bit lane becomes an 8-bit lane. With `lane_size` 2 or 3, each 32-bit lane becomes a 16-bit lane. The narrowed lanes of A, in lane order, fill the low 32 bits of the result, and those of B fill the high 32 bits. With `lane_size` 0 the result is zero.
- R10: After reset, `out_valid` and `result` are 0. A request taken with `in_valid` high on a rising edge shows its result, with `out_valid` high, after that edge. `out_valid` is low after any edge where `in_valid` was low.
- R11: While `in_valid` is low, `result` keeps its value. Opcodes 12 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| opcode | input | 4 | Operation select |
| lane_size | input | 2 | Lane layout select |
| sat_mode | input | 2 | Wrap / signed clamp / unsigned clamp |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B; B[7:0] is the shift count |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |

## Verification
Each request produces one fully determined word one cycle later, so an internal error shows at the ports on the very next `out_valid`. A carry that leaks across lanes alters the neighbouring lane's value. A wrong overflow test turns a clamp into a wrap, or the reverse, only for operands at the lane limits, so the bench drives those operands in every lane width. A wrong lane select or pack placement shuffles whole lanes. A valid or hold fault shows as a missing, extra or changed result in the cycle after the edge.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_ANDN = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_SLL  = 4'd6,
    OP_SRL  = 4'd7,
    OP_SRA  = 4'd8,
    OP_CEQ  = 4'd9,
    OP_CGT  = 4'd10,
    OP_PACK = 4'd11
  } alu_op_e;

  localparam logic [1:0] SAT_SIGNED   = 2'd1;
  localparam logic [1:0] SAT_UNSIGNED = 2'd2;

  // signed clamp of a 16-bit value to 8 bits
  function automatic logic [7:0] clamp16to8(input logic [15:0] x);
    if ($signed(x) > 16'sd127)       return 8'h7F;
    else if ($signed(x) < -16'sd128) return 8'h80;
    else                             return x[7:0];
  endfunction

  // signed clamp of a 32-bit value to 16 bits
  function automatic logic [15:0] clamp32to16(input logic [31:0] x);
    if ($signed(x) > 32'sd32767)       return 16'h7FFF;
    else if ($signed(x) < -32'sd32768) return 16'h8000;
    else                               return x[15:0];
  endfunction
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   opcode,
  input  logic [1:0]   sat_mode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [7:0]   shamt,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0]   sum_ext, dif_ext;
  logic         ovf_s_add, ovf_s_sub, wide_shift;
  logic [W-1:0] add_y, sub_y, sign_fill;

  assign sum_ext    = {1'b0, a} + {1'b0, b};
  assign dif_ext    = {1'b0, a} - {1'b0, b};
  assign ovf_s_add  = (a[W-1] == b[W-1]) && (sum_ext[W-1] != a[W-1]);
  assign ovf_s_sub  = (a[W-1] != b[W-1]) && (dif_ext[W-1] != a[W-1]);
  assign wide_shift = ({24'd0, shamt} >= W);
  assign sign_fill  = {W{a[W-1]}};

  always_comb begin
    case (sat_mode)
      SAT_SIGNED:   add_y = ovf_s_add ? (a[W-1] ? SMIN : SMAX) : sum_ext[W-1:0];
      SAT_UNSIGNED: add_y = sum_ext[W] ? {W{1'b1}} : sum_ext[W-1:0];
      default:      add_y = sum_ext[W-1:0];
    endcase
    case (sat_mode)
      SAT_SIGNED:   sub_y = ovf_s_sub ? (a[W-1] ? SMIN : SMAX) : dif_ext[W-1:0];
      SAT_UNSIGNED: sub_y = dif_ext[W] ? '0 : dif_ext[W-1:0];
      default:      sub_y = dif_ext[W-1:0];
    endcase
  end

  always_comb begin
    case (opcode)
      OP_ADD:  y = add_y;
      OP_SUB:  y = sub_y;
      OP_SLL:  y = wide_shift ? '0 : (a << shamt);
      OP_SRL:  y = wide_shift ? '0 : (a >> shamt);
      OP_SRA:  y = wide_shift ? sign_fill : W'($signed(a) >>> shamt);
      OP_CEQ:  y = {W{a == b}};
      OP_CGT:  y = {W{$signed(a) > $signed(b)}};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/simd_pack.sv
module simd_pack
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        lane_size,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int HALF = DATA_W / 2;
  localparam int N16  = DATA_W / 16;
  localparam int N32  = DATA_W / 32;

  logic [DATA_W-1:0] y_16to8, y_32to16;

  for (genvar i = 0; i < N16; i++) begin : g_p8
    assign y_16to8[i*8 +: 8]        = clamp16to8(a[i*16 +: 16]);
    assign y_16to8[HALF+i*8 +: 8]   = clamp16to8(b[i*16 +: 16]);
  end
  for (genvar i = 0; i < N32; i++) begin : g_p16
    assign y_32to16[i*16 +: 16]      = clamp32to16(a[i*32 +: 32]);
    assign y_32to16[HALF+i*16 +: 16] = clamp32to16(b[i*32 +: 32]);
  end

  always_comb begin
    case (lane_size)
      2'd0:    y = '0;
      2'd1:    y = y_16to8;
      default: y = y_32to16;
    endcase
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        opcode,
  input  logic [1:0]        lane_size,
  input  logic [1:0]        sat_mode,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int NB = DATA_W / 8;
  localparam int NH = DATA_W / 16;
  localparam int NW = DATA_W / 32;

  logic [DATA_W-1:0] y8, y16, y32, lane_y, pack_y, next_y;
  logic [7:0]        shamt;

  assign shamt = op_b[7:0];

  for (genvar i = 0; i < NB; i++) begin : g_l8
    simd_lane #(.W(8)) u_lane (
      .opcode(opcode), .sat_mode(sat_mode), .a(op_a[i*8 +: 8]),
      .b(op_b[i*8 +: 8]), .shamt(shamt), .y(y8[i*8 +: 8]));
  end
  for (genvar i = 0; i < NH; i++) begin : g_l16
    simd_lane #(.W(16)) u_lane (
      .opcode(opcode), .sat_mode(sat_mode), .a(op_a[i*16 +: 16]),
      .b(op_b[i*16 +: 16]), .shamt(shamt), .y(y16[i*16 +: 16]));
  end
  for (genvar i = 0; i < NW; i++) begin : g_l32
    simd_lane #(.W(32)) u_lane (
      .opcode(opcode), .sat_mode(sat_mode), .a(op_a[i*32 +: 32]),
      .b(op_b[i*32 +: 32]), .shamt(shamt), .y(y32[i*32 +: 32]));
  end

  simd_pack #(.DATA_W(DATA_W)) u_pack (
    .lane_size(lane_size), .a(op_a), .b(op_b), .y(pack_y));

  always_comb begin
    case (lane_size)
      2'd0:    lane_y = y8;
      2'd1:    lane_y = y16;
      default: lane_y = y32;
    endcase
  end

  always_comb begin
    case (opcode)
      OP_AND:  next_y = op_a & op_b;
      OP_ANDN: next_y = op_a & ~op_b;
      OP_OR:   next_y = op_a | op_b;
      OP_XOR:  next_y = op_a ^ op_b;
      OP_PACK: next_y = pack_y;
      OP_ADD, OP_SUB, OP_SLL, OP_SRL, OP_SRA, OP_CEQ, OP_CGT:
               next_y = lane_y;
      default: next_y = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_y;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result)); // R11
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode >= 4'd12) |=> (result == '0)); // R11
  AST_WIDE_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == OP_SLL || opcode == OP_SRL) && op_b[7:0] >= 8'd32)
      |=> (result == '0)); // R7

  for (genvar i = 0; i < NB; i++) begin : g_chk
    AST_MASK_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (opcode == OP_CEQ || opcode == OP_CGT))
        |=> (result[i*8 +: 8] == 8'h00 || result[i*8 +: 8] == 8'hFF)); // R8
    AST_USAT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == OP_ADD && sat_mode == SAT_UNSIGNED && lane_size == 2'd0)
        |=> (result[i*8 +: 8] >= $past(op_a[i*8 +: 8]))); // R4
  end
endmodule

// File: tb/simd_alu_tb.sv
module simd_alu_tb;
  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  opcode = '0;
  logic [1:0]  lane_size = '0;
  logic [1:0]  sat_mode = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [63:0] result;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    running = 1'b0;
  bit    done = 1'b0;
  item_t sb_q[$];
  logic [63:0] last_res;

  always #10 clk = ~clk;

  simd_alu u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .lane_size(lane_size), .sat_mode(sat_mode), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint clampl(longint v, longint lo, longint hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  // independent reference, one lane at a time on integers
  function automatic logic [63:0] model(logic [3:0] op, logic [1:0] sz, logic [1:0] sm,
                                        logic [63:0] a, logic [63:0] b);
    int w, cnt, sw, nw, n;
    longint mx, ua, ub, sa, sb, smax, smin, r;
    logic [63:0] o;
    o = '0;
    case (op)
      4'd2: return a & b;
      4'd3: return a & ~b;
      4'd4: return a | b;
      4'd5: return a ^ b;
      default: ;
    endcase
    if (op >= 4'd12) return '0;
    if (op == 4'd11) begin
      if (sz == 2'd0) return '0;
      sw = (sz == 2'd1) ? 16 : 32;
      nw = sw / 2;
      n  = 64 / sw;
      mx = (longint'(1) << sw) - 1;
      smax = (longint'(1) << (nw - 1)) - 1;
      smin = -smax - 1;
      for (int i = 0; i < n; i++) begin
        ua = longint'(a >> (i * sw)) & mx;
        ub = longint'(b >> (i * sw)) & mx;
        sa = (ua > (mx >> 1)) ? ua - mx - 1 : ua;
        sb = (ub > (mx >> 1)) ? ub - mx - 1 : ub;
        r = clampl(sa, smin, smax) & ((longint'(1) << nw) - 1);
        o = o | (64'(r) << (i * nw));
        r = clampl(sb, smin, smax) & ((longint'(1) << nw) - 1);
        o = o | (64'(r) << ((i + n) * nw));
      end
      return o;
    end
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    cnt = int'(b[7:0]);
    mx = (longint'(1) << w) - 1;
    smax = (longint'(1) << (w - 1)) - 1;
    smin = -smax - 1;
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'(a >> (i * w)) & mx;
      ub = longint'(b >> (i * w)) & mx;
      sa = (ua > smax) ? ua - mx - 1 : ua;
      sb = (ub > smax) ? ub - mx - 1 : ub;
      case (op)
        4'd0: r = (sm == 2'd1) ? clampl(sa + sb, smin, smax) :
                  (sm == 2'd2) ? clampl(ua + ub, 0, mx) : ua + ub;
        4'd1: r = (sm == 2'd1) ? clampl(sa - sb, smin, smax) :
                  (sm == 2'd2) ? clampl(ua - ub, 0, mx) : ua - ub;
        4'd6: r = (cnt >= w) ? 0 : ua << cnt;
        4'd7: r = (cnt >= w) ? 0 : ua >> cnt;
        4'd8: r = (cnt >= w) ? ((sa < 0) ? -1 : 0) : sa >>> cnt;
        4'd9: r = (ua == ub) ? -1 : 0;
        default: r = (sa > sb) ? -1 : 0;
      endcase
      o = o | ((64'(r) & 64'(mx)) << (i * w));
    end
    return o;
  endfunction

  function automatic string op_tag(logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd5: return "R5";
      4'd6, 4'd7, 4'd8: return "R6";
      4'd9, 4'd10: return "R8";
      4'd11: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic send(input logic [3:0] op, input logic [1:0] sz, input logic [1:0] sm,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    item_t it;
    @(negedge clk);
    opcode = op; lane_size = sz; sat_mode = sm; op_a = a; op_b = b; in_valid = 1'b1;
    it.exp = model(op, sz, sm, a, b);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      op_a = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  // monitor: pops the scoreboard as results appear
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (running) begin
        if (out_valid) begin
          if (sb_q.size() == 0) check(1'b0, "R10 unexpected out_valid", result, '0);
          else begin
            it = sb_q.pop_front();
            check(result === it.exp, it.tag, result, it.exp);
          end
        end else begin
          check(sb_q.size() == 0, "R10 missing out_valid", result, '0);
          check(result === last_res, "R11 hold while idle", result, last_res);
        end
        last_res = result;
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      check(1'b0, "watchdog expired", '0, '0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10 reset out_valid", 64'(out_valid), '0);
    check(result === '0, "R10 reset result", result, '0);
    rst_n = 1'b1;
    last_res = '0;
    running = 1'b1;
    idle(2);

    // R1: lane carry isolation in each layout
    send(4'd0, 2'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R1 byte carry cut");
    send(4'd0, 2'd1, 2'd0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, "R1 half carry cut");
    send(4'd1, 2'd2, 2'd0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, "R1 word borrow cut");
    send(4'd0, 2'd3, 2'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, "R1 size 3 as word");
    // R2 wrap
    send(4'd1, 2'd0, 2'd3, 64'h0010_2030_4050_6070, 64'h0111_0111_0111_0111, "R2 sub wrap");
    send(4'd0, 2'd1, 2'd0, 64'h7FFF_8000_1234_FFFF, 64'h0001_8000_4321_FFFF, "R2 add wrap");
    // R3 signed clamp
    send(4'd0, 2'd0, 2'd1, 64'h7F80_7F80_0102_FF00, 64'h0180_01FF_0102_FF00, "R3 sadd byte");
    send(4'd1, 2'd1, 2'd1, 64'h7FFF_8000_0005_FFFF, 64'hFFFF_0001_0007_7FFF, "R3 ssub half");
    send(4'd0, 2'd2, 2'd1, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, "R3 sadd word");
    // R4 unsigned clamp
    send(4'd0, 2'd0, 2'd2, 64'hFF80_FF10_0001_F0F0, 64'h0180_0111_FEFF_1010, "R4 uadd byte");
    send(4'd1, 2'd1, 2'd2, 64'h0000_0005_1000_FFFF, 64'h0001_0007_0FFF_FFFF, "R4 usub half");
    send(4'd0, 2'd2, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFE, "R4 uadd word");
    // R5 logic
    send(4'd2, 2'd0, 2'd1, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_AAAA, "R5 and");
    send(4'd3, 2'd1, 2'd0, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_AAAA, "R5 andnot");
    send(4'd4, 2'd2, 2'd0, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_AAAA, "R5 or");
    send(4'd5, 2'd3, 2'd2, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_AAAA, "R5 xor");
    // R6 shifts
    send(4'd6, 2'd0, 2'd0, 64'h8123_4567_89AB_CDEF, 64'h3, "R6 sll byte");
    send(4'd7, 2'd1, 2'd0, 64'h8123_4567_89AB_CDEF, 64'h5, "R6 srl half");
    send(4'd8, 2'd2, 2'd0, 64'h8123_4567_09AB_CDEF, 64'h7, "R6 sra word");
    send(4'd8, 2'd0, 2'd0, 64'h80FF_7F01_C040_0102, 64'h1, "R6 sra byte");
    // R7 wide counts
    send(4'd6, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8, "R7 sll count=8");
    send(4'd7, 2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h10, "R7 srl count=16");
    send(4'd8, 2'd0, 2'd0, 64'h8000_7F01_FF00_80C0, 64'hC8, "R7 sra count=200");
    send(4'd8, 2'd2, 2'd0, 64'h8000_0000_7FFF_FFFF, 64'h20, "R7 sra count=32");
    // R8 compares
    send(4'd9, 2'd0, 2'd0, 64'h0102_0304_0506_0708, 64'h0102_0004_0500_0708, "R8 eq byte");
    send(4'd10, 2'd0, 2'd0, 64'h80FF_7F01_0000_05FF, 64'h7F00_8002_0000_0480, "R8 gt byte");
    send(4'd10, 2'd1, 2'd0, 64'h8000_0001_FFFF_7FFF, 64'h7FFF_0000_FFFE_8000, "R8 gt half");
    send(4'd9, 2'd2, 2'd0, 64'h1234_5678_0000_0001, 64'h1234_5678_0000_0000, "R8 eq word");
    // R9 packs
    send(4'd11, 2'd1, 2'd0, 64'h0080_FF7F_007F_FF80, 64'h8000_7FFF_0005_FFFB, "R9 pack 16to8");
    send(4'd11, 2'd2, 2'd0, 64'h0000_8000_FFFF_7FFF, 64'h8000_0000_0000_1234, "R9 pack 32to16");
    send(4'd11, 2'd0, 2'd0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R9 pack size 0");
    // R11 reserved opcodes and idle hold
    send(4'd13, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R11 reserved op");
    send(4'd0, 2'd0, 2'd0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, "R10 before idle");
    idle(4);
    send(4'd5, 2'd0, 2'd0, 64'h1, 64'h2, "R10 after idle");

    for (int i = 0; i < 300; i++) begin
      logic [3:0]  rop;
      logic [63:0] ra, rb;
      rop = 4'($urandom_range(0, 11));
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (rop >= 4'd6 && rop <= 4'd8) rb[7:0] = 8'($urandom_range(0, 40));
      send(rop, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), ra, rb, op_tag(rop));
      if (i % 17 == 0) idle(1);
    end
    idle(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule